// File: doc/BRIEF.md
# Multiplexed LCD Backplane Waveform Sequencer

This block is the digital timing core of a passive LCD driver. It steps through the time slots of a drive frame and, for each backplane and segment pin, produces a 2-bit code. The code tells the analog output stage which bias voltage to connect. The block supports static drive and 1:2, 1:3 and 1:4 multiplexing. Bias can be static, 1/2 or 1/3. Polarity alternates from frame to frame, so every pixel sees zero net DC.

Segment data comes from an internal column store. Each segment has a 4-bit column, and bit r of the column belongs to row r. Row r is shown while backplane r is active. In static and 1:2 drive, an alternate-bank option displays rows 2 and 3 in place of rows 0 and 1. This lets a new image be prepared in the hidden rows and shown with a single switch.

Several drivers in a cascade share one open-drain, active-low sync wire. Each driver pulls the wire low during the last slot of every odd frame. A driver that sees another driver pull the wire low jumps to that same point in its own sequence.

The sequencer FSM has two states:
- `ST_BLANK`: all outputs are at VSS and the slot and polarity counters are cleared.
- `ST_SCAN`: the sequencer steps through the slots.

It has two transitions:
- **start**: from `ST_BLANK` to `ST_SCAN` when `scan_en` is sampled high.
- **stop**: from `ST_SCAN` to `ST_BLANK` when `scan_en` is sampled low.

Inside `ST_SCAN` there are three events:
- **advance**: a slot-timer tick moves to the next slot.
- **wrap**: a tick in the last slot returns to slot 0 and inverts polarity.
- **realign**: an external sync edge forces the sequence to the last slot of an odd frame.

Top module: `lcdw_sequencer`

## Requirements
- R1: Level codes are 0 = VSS, 1 = lower intermediate (VLCD/3, or VLCD/2 under 1/2 bias), 2 = 2·VLCD/3, 3 = VLCD. After reset, and from the second rising edge after `scan_en` is sampled low, every backplane and segment code is 0 and `sync_pull_o` is 0.
- R2: `mux_mode` selects the number of slots per frame: 0 gives four slots (1:4), 1 gives one slot (static), 2 gives two and 3 gives three. Slots run 0..N-1, and in slot k backplane k is the active one. All-zero `mux_mode` and `bias_sel` select 1:4 drive with 1/3 bias.
- R3: The first frame after start is even (polarity 0). Frames alternate even and odd, and in static drive every slot is a whole frame.
- R4: With 1/3 bias (`bias_sel` 0 or 3), the codes are:
  - even frame: active backplane 3, idle backplane 1, on segment 0, off segment 2;
  - odd frame: 0, 2, 3 and 1 respectively.
- R5: With 1/2 bias (`bias_sel` 1), the codes are:
  - even frame: active backplane 3, idle backplane 1, on segment 0, off segment 1;
  - odd frame: 0, 1, 3 and 1 respectively.
- R6: With static bias (`bias_sel` 2), the codes are:
  - even frame: active backplane 3, idle backplane 0, on segment 0, off segment 3;
  - odd frame: 0, 3, 3 and 0 respectively.
- R7: A backplane whose index is not below the slot count carries the idle code for the whole frame.
- R8: In slot k a segment is on when bit `row` of its column is 1. `row` is chosen as follows:
  - static drive: row 0, or row 2 when `bank_alt` is 1;
  - 1:2 drive: row k, or row k+2 when `bank_alt` is 1;
  - 1:3 and 1:4 drive: always row k, and `bank_alt` has no effect.
- R9: Each slot lasts SLOT_BASE + `frame_presc`·SLOT_STEP clock cycles.
- R10: `sync_pull_o` is high exactly while the outputs show the last slot of an odd frame.
- R11: A high-to-low transition of `sync_n_i` passes through two synchronizer flops. If it is seen while this driver is not in its own pull window, the driver moves to the last slot of an odd frame and restarts the slot timer. A transition seen inside the driver's own window has no effect.
- R12: A column write sampled at a rising edge appears on the segment outputs after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | 1 = run the waveform, 0 = blank to VSS |
| mux_mode | input | 2 | Drive multiplex selection (R2) |
| bias_sel | input | 2 | Bias scheme selection (R4 to R6) |
| bank_alt | input | 1 | Show alternate rows in static and 1:2 drive |
| frame_presc | input | PRESC_W | Slot length code (R9) |
| wr_en | input | 1 | Column write strobe |
| wr_col | input | AW | Column index for the write |
| wr_bits | input | 4 | Row bits of the column, bit r = row r |
| sync_n_i | input | 1 | Sampled level of the shared active-low sync wire |
| sync_pull_o | output | 1 | 1 = pull the sync wire low |
| bp_lvl_o | output | 8 | Backplane codes, backplane b at bits [2b+1:2b] |
| seg_lvl_o | output | 2·NUM_SEG | Segment codes, segment s at bits [2s+1:2s] |

## Verification
The slot and polarity registers change at a timer edge, and the output registers follow one edge later. A started run therefore shows slot k from edge kL+1 to edge (k+1)L+1, where L is the slot length. The bench samples each slot at its middle, on a falling edge. Stopping takes two edges to reach all-VSS outputs, and the bench waits three before checking. A column write shows up one edge after it is stored, so the bench writes in mid-slot and checks two falling edges later, inside the same slot. An external sync edge acts three edges after the wire falls (two synchronizer flops and one detector flop), and the outputs follow one edge after that. The bench counts these edges and then samples the realigned slot at its middle.

// File: rtl/lcdw_pkg.sv
`timescale 1ns/1ps
package lcdw_pkg;

    typedef enum logic [1:0] {
        MUX_QUAD   = 2'd0,
        MUX_STATIC = 2'd1,
        MUX_DUAL   = 2'd2,
        MUX_TRIPLE = 2'd3
    } mux_e;

    typedef enum logic [1:0] {
        BIAS_THIRD  = 2'd0,
        BIAS_HALF   = 2'd1,
        BIAS_STATIC = 2'd2,
        BIAS_RSVD   = 2'd3
    } bias_e;

    typedef enum logic [1:0] {
        ROLE_BP_ACT,
        ROLE_BP_IDLE,
        ROLE_SEG_ON,
        ROLE_SEG_OFF
    } role_e;

    typedef enum logic {
        ST_BLANK = 1'b0,
        ST_SCAN  = 1'b1
    } seq_st_e;

    localparam logic [1:0] LVL_VSS  = 2'd0;
    localparam logic [1:0] LVL_LO   = 2'd1;
    localparam logic [1:0] LVL_HI   = 2'd2;
    localparam logic [1:0] LVL_VLCD = 2'd3;

    // number of slots in one frame for a drive selection
    function automatic logic [2:0] slot_count(mux_e m);
        unique case (m)
            MUX_STATIC: return 3'd1;
            MUX_DUAL:   return 3'd2;
            MUX_TRIPLE: return 3'd3;
            default:    return 3'd4;
        endcase
    endfunction

    // level code for a pin role; odd frames mirror the extremes
    function automatic logic [1:0] level_of(bias_e bias, logic odd, role_e role);
        logic [1:0] near_lvl;
        logic [1:0] far_lvl;
        near_lvl = odd ? LVL_VSS : LVL_VLCD;
        far_lvl  = odd ? LVL_VLCD : LVL_VSS;
        unique case (role)
            ROLE_BP_ACT: return near_lvl;
            ROLE_SEG_ON: return far_lvl;
            ROLE_BP_IDLE: begin
                unique case (bias)
                    BIAS_HALF:   return LVL_LO;
                    BIAS_STATIC: return far_lvl;
                    default:     return odd ? LVL_HI : LVL_LO;
                endcase
            end
            default: begin
                unique case (bias)
                    BIAS_HALF:   return LVL_LO;
                    BIAS_STATIC: return near_lvl;
                    default:     return odd ? LVL_LO : LVL_HI;
                endcase
            end
        endcase
    endfunction

endpackage

// File: rtl/lcdw_slot_timer.sv
`timescale 1ns/1ps
module lcdw_slot_timer #(
    parameter int SLOT_BASE = 4,
    parameter int SLOT_STEP = 2,
    parameter int PRESC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int MAX_LEN = SLOT_BASE + ((1 << PRESC_W) - 1) * SLOT_STEP;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] cnt_q;

    assign len  = LEN_W'(SLOT_BASE) + LEN_W'(presc) * LEN_W'(SLOT_STEP);
    assign tick = run && !restart && (cnt_q >= len - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end
endmodule

// File: rtl/lcdw_sync_port.sv
`timescale 1ns/1ps
module lcdw_sync_port (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n_i,
    output logic fall
);
    logic meta_q;
    logic line_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            line_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= sync_n_i;
            line_q <= meta_q;
            prev_q <= line_q;
        end
    end

    assign fall = prev_q && !line_q;
endmodule

// File: rtl/lcdw_colmem.sv
`timescale 1ns/1ps
module lcdw_colmem #(
    parameter int NUM_SEG = 160,
    parameter int ROWS    = 4,
    localparam int AW     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int RW     = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [ROWS-1:0]    wr_bits,
    input  logic [RW-1:0]      rd_row,
    output logic [NUM_SEG-1:0] rd_bits
);
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_col
        logic [ROWS-1:0] bits_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (wr_en && wr_addr == AW'(s)) begin
                bits_q <= wr_bits;
            end
        end
        assign rd_bits[s] = bits_q[rd_row];
    end
endmodule

// File: rtl/lcdw_sequencer.sv
`timescale 1ns/1ps
module lcdw_sequencer
    import lcdw_pkg::*;
#(
    parameter int NUM_SEG   = 160,
    parameter int SLOT_BASE = 4,
    parameter int SLOT_STEP = 2,
    parameter int PRESC_W   = 3,
    localparam int NUM_BP   = 4,
    localparam int AW       = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_en,
    input  logic [1:0]           mux_mode,
    input  logic [1:0]           bias_sel,
    input  logic                 bank_alt,
    input  logic [PRESC_W-1:0]   frame_presc,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_col,
    input  logic [NUM_BP-1:0]    wr_bits,
    input  logic                 sync_n_i,
    output logic                 sync_pull_o,
    output logic [2*NUM_BP-1:0]  bp_lvl_o,
    output logic [2*NUM_SEG-1:0] seg_lvl_o
);
    seq_st_e st_q, st_d;
    logic [1:0]         slot_q;
    logic               pol_q;
    logic [2:0]         nslots;
    logic [1:0]         last_idx;
    logic               own_window;
    logic               st_scan;
    logic               slot_tick;
    logic               sync_fall;
    logic               realign;
    logic [1:0]         row_sel;
    logic [NUM_SEG-1:0] row_bits;
    mux_e               mode_e;
    bias_e              bias_e_v;

    assign mode_e     = mux_e'(mux_mode);
    assign bias_e_v   = bias_e'(bias_sel);
    assign nslots     = slot_count(mode_e);
    assign last_idx   = 2'(nslots - 3'd1);
    assign own_window = (slot_q == last_idx) && pol_q;
    assign st_scan    = (st_q == ST_SCAN);
    assign realign    = st_scan && sync_fall && !own_window;

    lcdw_slot_timer #(
        .SLOT_BASE(SLOT_BASE),
        .SLOT_STEP(SLOT_STEP),
        .PRESC_W  (PRESC_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_scan),
        .restart(realign),
        .presc  (frame_presc),
        .tick   (slot_tick)
    );

    lcdw_sync_port u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_n_i(sync_n_i),
        .fall    (sync_fall)
    );

    lcdw_colmem #(
        .NUM_SEG(NUM_SEG),
        .ROWS   (NUM_BP)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_col),
        .wr_bits(wr_bits),
        .rd_row (row_sel),
        .rd_bits(row_bits)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BLANK: if (scan_en)  st_d = ST_SCAN;
            ST_SCAN:  if (!scan_en) st_d = ST_BLANK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_BLANK;
        else        st_q <= st_d;
    end

    // slot and frame polarity counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= 2'd0;
            pol_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_BLANK: begin
                    slot_q <= 2'd0;
                    pol_q  <= 1'b0;
                end
                ST_SCAN: begin
                    if (realign) begin
                        slot_q <= last_idx;
                        pol_q  <= 1'b1;
                    end else if (slot_tick) begin
                        if (slot_q >= last_idx) begin
                            slot_q <= 2'd0;
                            pol_q  <= !pol_q;
                        end else begin
                            slot_q <= slot_q + 2'd1;
                        end
                    end
                end
            endcase
        end
    end

    // memory row shown in the current slot
    always_comb begin
        unique case (mode_e)
            MUX_STATIC: row_sel = bank_alt ? 2'd2 : 2'd0;
            MUX_DUAL:   row_sel = {bank_alt, slot_q[0]};
            default:    row_sel = slot_q;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_pull_o <= 1'b0;
        end else begin
            unique case (st_q)
                ST_BLANK: sync_pull_o <= 1'b0;
                ST_SCAN:  sync_pull_o <= own_window;
            endcase
        end
    end

    for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
        logic [1:0] lvl_d;
        logic [1:0] lvl_q;
        always_comb begin
            if (slot_q == 2'(b) && 3'(b) < nslots)
                lvl_d = level_of(bias_e_v, pol_q, ROLE_BP_ACT);
            else
                lvl_d = level_of(bias_e_v, pol_q, ROLE_BP_IDLE);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q <= LVL_VSS;
            end else begin
                unique case (st_q)
                    ST_BLANK: lvl_q <= LVL_VSS;
                    ST_SCAN:  lvl_q <= lvl_d;
                endcase
            end
        end
        assign bp_lvl_o[2*b +: 2] = lvl_q;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [1:0] lvl_d;
        logic [1:0] lvl_q;
        always_comb begin
            lvl_d = level_of(bias_e_v, pol_q, row_bits[s] ? ROLE_SEG_ON : ROLE_SEG_OFF);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q <= LVL_VSS;
            end else begin
                unique case (st_q)
                    ST_BLANK: lvl_q <= LVL_VSS;
                    ST_SCAN:  lvl_q <= lvl_d;
                endcase
            end
        end
        assign seg_lvl_o[2*s +: 2] = lvl_q;
    end
endmodule

// File: rtl/lcdw_sequencer_chk.sv
`timescale 1ns/1ps
module lcdw_sequencer_chk #(
    parameter int NUM_SEG = 160
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scan_en,
    input logic [1:0]           bias_sel,
    input logic                 sync_pull_o,
    input logic [7:0]           bp_lvl_o,
    input logic [2*NUM_SEG-1:0] seg_lvl_o,
    input logic                 st_scan,
    input logic [1:0]           slot_q,
    input logic                 pol_q,
    input logic [2:0]           nslots,
    input logic                 slot_tick,
    input logic                 realign
);
    logic [3:0] bp_extreme;
    always_comb begin
        for (int b = 0; b < 4; b++) begin
            bp_extreme[b] = (bp_lvl_o[2*b +: 2] == 2'd0) || (bp_lvl_o[2*b +: 2] == 2'd3);
        end
    end

    p_blank_vss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(scan_en, 2) |-> (bp_lvl_o == '0 && seg_lvl_o == '0 && !sync_pull_o));

    // R4: under 1/3 bias exactly one backplane sits at an extreme level
    p_single_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_scan) && $past(bias_sel) == 2'd0 && {1'b0, $past(slot_q)} < $past(nslots))
        |-> $countones(bp_extreme) == 1);

    p_wrap_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_scan && slot_tick && !realign && {1'b0, slot_q} >= nslots - 3'd1)
        |=> (slot_q == 2'd0 && pol_q != $past(pol_q)));

    p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_scan && !slot_tick && !realign) |=> ($stable(slot_q) && $stable(pol_q)));

    p_pull_odd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pull_o |-> $past(pol_q));

    p_realign_r11: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (pol_q && slot_q == 2'($past(nslots) - 3'd1)));
endmodule

bind lcdw_sequencer lcdw_sequencer_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .bias_sel   (bias_sel),
    .sync_pull_o(sync_pull_o),
    .bp_lvl_o   (bp_lvl_o),
    .seg_lvl_o  (seg_lvl_o),
    .st_scan    (st_scan),
    .slot_q     (slot_q),
    .pol_q      (pol_q),
    .nslots     (nslots),
    .slot_tick  (slot_tick),
    .realign    (realign)
);

// File: tb/tb_lcdw_sequencer.sv
`timescale 1ns/1ps
module tb_lcdw_sequencer;
    localparam int NSEG  = 4;
    localparam int SBASE = 4;
    localparam int SSTEP = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scan_en = 1'b0;
    logic [1:0]       mux_mode = 2'd0;
    logic [1:0]       bias_sel = 2'd0;
    logic             bank_alt = 1'b0;
    logic [2:0]       frame_presc = 3'd0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_col = 2'd0;
    logic [3:0]       wr_bits = 4'd0;
    logic             ext_pull = 1'b0;
    logic             sync_line;
    logic             sync_pull_o;
    logic [7:0]       bp_lvl_o;
    logic [2*NSEG-1:0] seg_lvl_o;

    int n_chk = 0;
    int n_fail = 0;
    int cur_len = SBASE;
    logic [3:0] colmem [NSEG];

    always #2.5 clk = ~clk;

    assign sync_line = ~(sync_pull_o | ext_pull);

    lcdw_sequencer #(
        .NUM_SEG(NSEG), .SLOT_BASE(SBASE), .SLOT_STEP(SSTEP), .PRESC_W(3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mux_mode(mux_mode),
        .bias_sel(bias_sel), .bank_alt(bank_alt), .frame_presc(frame_presc),
        .wr_en(wr_en), .wr_col(wr_col), .wr_bits(wr_bits), .sync_n_i(sync_line),
        .sync_pull_o(sync_pull_o), .bp_lvl_o(bp_lvl_o), .seg_lvl_o(seg_lvl_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // role: 0 active bp, 1 idle bp, 2 seg on, 3 seg off
    function automatic logic [1:0] exp_lvl(input logic [1:0] bias, input logic odd, input int role);
        logic [7:0] tbl;
        if (bias == 2'd1)      tbl = odd ? {2'd1, 2'd3, 2'd1, 2'd0} : {2'd1, 2'd0, 2'd1, 2'd3};
        else if (bias == 2'd2) tbl = odd ? {2'd0, 2'd3, 2'd3, 2'd0} : {2'd3, 2'd0, 2'd0, 2'd3};
        else                   tbl = odd ? {2'd1, 2'd3, 2'd2, 2'd0} : {2'd2, 2'd0, 2'd1, 2'd3};
        return tbl[2*role +: 2];
    endfunction

    function automatic int slots_of(input logic [1:0] m);
        case (m)
            2'd1:    return 1;
            2'd2:    return 2;
            2'd3:    return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int row_of(input logic [1:0] m, input logic bank, input int slot);
        if (m == 2'd1) return bank ? 2 : 0;
        if (m == 2'd2) return bank ? slot + 2 : slot;
        return slot;
    endfunction

    task automatic check_slot(input string req, input int slot, input logic odd);
        logic [7:0]        ebp;
        logic [2*NSEG-1:0] eseg;
        int n;
        int row;
        n = slots_of(mux_mode);
        row = row_of(mux_mode, bank_alt, slot);
        for (int b = 0; b < 4; b++)
            ebp[2*b +: 2] = (b == slot && b < n) ? exp_lvl(bias_sel, odd, 0) : exp_lvl(bias_sel, odd, 1);
        for (int s = 0; s < NSEG; s++)
            eseg[2*s +: 2] = colmem[s][row] ? exp_lvl(bias_sel, odd, 2) : exp_lvl(bias_sel, odd, 3);
        chk(req, "backplanes", 32'(bp_lvl_o), 32'(ebp));
        chk(req, "segments", 32'(seg_lvl_o), 32'(eseg));
        chk("R10", "sync pull", 32'(sync_pull_o), 32'((slot == n - 1) && odd));
    endtask

    task automatic write_col(input int c, input logic [3:0] bits);
        wr_en = 1'b1;
        wr_col = 2'(c);
        wr_bits = bits;
        colmem[c] = bits;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_scan();
        scan_en = 1'b1;
        wait_n(1 + cur_len / 2);
    endtask

    task automatic stop_scan(input string req);
        scan_en = 1'b0;
        wait_n(3);
        chk(req, "blank backplanes", 32'(bp_lvl_o), 32'd0);
        chk(req, "blank segments", 32'(seg_lvl_o), 32'd0);
        chk(req, "blank sync pull", 32'(sync_pull_o), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "reset backplanes", 32'(bp_lvl_o), 32'd0);
        chk("R1", "reset segments", 32'(seg_lvl_o), 32'd0);
        chk("R1", "reset sync pull", 32'(sync_pull_o), 32'd0);
    endtask

    task automatic t_quad_third();
        mux_mode = 2'd0; bias_sel = 2'd0; bank_alt = 1'b0;
        start_scan();
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < 4; k++) begin
                check_slot("R2,R3,R4,R8", k, f[0]);
                wait_n(cur_len);
            end
        stop_scan("R1");
    endtask

    task automatic t_triple_half();
        mux_mode = 2'd3; bias_sel = 2'd1; bank_alt = 1'b0;
        start_scan();
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < 3; k++) begin
                check_slot("R5,R7", k, f[0]);
                wait_n(cur_len);
            end
        stop_scan("R1");
    endtask

    task automatic t_static_bank();
        mux_mode = 2'd1; bias_sel = 2'd2; bank_alt = 1'b0;
        start_scan();
        for (int i = 0; i < 4; i++) begin
            check_slot("R6,R3,R11", 0, i[0]);
            wait_n(cur_len);
        end
        stop_scan("R1");
        bank_alt = 1'b1;
        start_scan();
        for (int i = 0; i < 2; i++) begin
            check_slot("R8", 0, i[0]);
            wait_n(cur_len);
        end
        stop_scan("R1");
    endtask

    task automatic t_dual_bank_write();
        mux_mode = 2'd2; bias_sel = 2'd1; bank_alt = 1'b1;
        start_scan();
        check_slot("R8", 0, 1'b0);
        write_col(1, 4'b0101);
        wait_n(1);
        check_slot("R12", 0, 1'b0);
        wait_n(2);
        check_slot("R8", 1, 1'b0);
        wait_n(cur_len);
        check_slot("R8", 0, 1'b1);
        wait_n(cur_len);
        check_slot("R8", 1, 1'b1);
        stop_scan("R1");
    endtask

    task automatic t_presc();
        mux_mode = 2'd0; bias_sel = 2'd0; bank_alt = 1'b0;
        frame_presc = 3'd2;
        cur_len = SBASE + 2 * SSTEP;
        start_scan();
        check_slot("R9", 0, 1'b0);
        wait_n(4);
        check_slot("R9", 0, 1'b0);
        wait_n(2);
        check_slot("R9", 1, 1'b0);
        stop_scan("R1");
        frame_presc = 3'd0;
        cur_len = SBASE;
    endtask

    task automatic t_realign();
        mux_mode = 2'd0; bias_sel = 2'd0; bank_alt = 1'b1;
        start_scan();
        check_slot("R8", 0, 1'b0);
        wait_n(cur_len);
        check_slot("R8", 1, 1'b0);
        ext_pull = 1'b1;
        wait_n(2);
        ext_pull = 1'b0;
        wait_n(3);
        check_slot("R11", 3, 1'b1);
        wait_n(cur_len);
        check_slot("R11", 0, 1'b0);
        wait_n(cur_len);
        check_slot("R11", 1, 1'b0);
        stop_scan("R1");
    endtask

    initial begin
        for (int s = 0; s < NSEG; s++) colmem[s] = 4'd0;
        wait_n(4);
        t_reset();
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        write_col(0, 4'b0001);
        write_col(1, 4'b1010);
        write_col(2, 4'b1111);
        write_col(3, 4'b0110);
        t_quad_third();
        t_triple_half();
        t_static_bank();
        t_dual_bank_write();
        t_presc();
        t_realign();
        summary();
    end
endmodule